// File: doc/BRIEF.md
# CPU Machine-Cycle Clock Generator with Standby Control

This block produces the machine-cycle enable for a small processor core. Two clock sources reach it as single-cycle tick strobes in the fabric clock domain: a fast main oscillator and a slow subsystem oscillator. Main ticks first pass a selectable prescaler (divide by 16, 2 or 1). A source selector then picks the prescaled main stream or the raw subsystem stream. A fixed divide-by-4 stage follows it. Each wrap of that stage is one machine cycle, and the block marks it with a one-cycle `cpu_ce` pulse.

Software writes a requested source and prescale code. The active setting takes the new value only at a machine-cycle boundary, so no machine cycle is ever cut short. Two standby modes are handled by flags. The halt mode stops `cpu_ce` while the dividers keep running. The stop mode also switches off the main oscillator enable, freezes the dividers and forces the prescale code back to the slowest setting. Leaving halt needs only a release request. Leaving stop turns the oscillator back on and then holds the CPU clock off until a wait-release pulse from an interval timer shows that the oscillator has settled.

Top module: `cpu_clkgen`

## Requirements
- R1: After reset, `osc_en` is 1, `halt_flag`, `stop_flag`, `wait_flag` and `cpu_ce` are 0, `cur_sub` is 0 and `cur_pre` is 2'b00.
- R2: With the main source active and `main_tick` high every cycle, `cpu_ce` pulses for one cycle once every 64 cycles for prescale code 2'b00, every 8 cycles for 2'b01 and every 4 cycles for 2'b10 or 2'b11.
- R3: With the subsystem source active (`cur_sub` = 1), `cpu_ce` pulses once per 4 `sub_tick` strobes, and `main_tick` has no effect on the period.
- R4: A configuration write (`cfg_we`) changes `cur_sub` and `cur_pre` only at the next machine-cycle boundary. The interval that contains the write keeps its old length.
- R5: A `halt_req` while running sets `halt_flag`. `cpu_ce` then stays low and `osc_en` stays 1.
- R6: An `irq_release` clears `halt_flag`, and `cpu_ce` pulses again no later than one machine cycle afterwards.
- R7: A `stop_req` while running sets `stop_flag`, drops `osc_en` to 0 and forces both the requested and the active prescale code to 2'b00. No `cpu_ce` pulse occurs while stopped.
- R8: An `irq_release` while stopped clears `stop_flag`, raises `osc_en` and sets `wait_flag`. `cpu_ce` stays low until `wait_release` arrives, and then resumes at the slow prescale. A `wait_release` while stopped has no effect.
- R9: When `halt_req` and `stop_req` arrive together, stop wins. Standby requests are ignored while any standby flag is set, so at most one flag is ever set.
- R10: Reset during stop or with the subsystem source selected returns the block to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | Main oscillator tick strobe |
| sub_tick | input | 1 | Subsystem oscillator tick strobe |
| cfg_we | input | 1 | Write strobe for the requested configuration |
| cfg_sub | input | 1 | Requested source: 1 = subsystem, 0 = main |
| cfg_pre | input | 2 | Requested prescale code: 00 = /16, 01 = /2, 1x = /1 |
| halt_req | input | 1 | Halt instruction strobe |
| stop_req | input | 1 | Stop instruction strobe |
| irq_release | input | 1 | Standby-release request from the interrupt logic |
| wait_release | input | 1 | Wait-release pulse from the interval timer |
| cpu_ce | output | 1 | One-cycle machine-cycle enable |
| osc_en | output | 1 | Main oscillator enable |
| halt_flag | output | 1 | Halt mode active |
| stop_flag | output | 1 | Stop mode active |
| wait_flag | output | 1 | Waiting for oscillator settling after stop |
| cur_sub | output | 1 | Active source |
| cur_pre | output | 2 | Active prescale code |

## Verification
The assertions take every strobe input to be a single-cycle pulse in the fabric clock domain. They also take the divide-by-4 stage to give boundaries at least two cycles apart, so a `cpu_ce` pulse never lasts more than one cycle. The bench drives every request and configuration write for exactly one cycle and clears it at the next falling edge. It raises `sub_tick` on one cycle in eight from a free-running counter. It drives `main_tick` either constantly high or constantly low, so the expected periods follow directly from the divide ratios.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
  localparam int unsigned CFG_W = 2;
  typedef logic [CFG_W-1:0] pre_code_t;

  localparam pre_code_t PRE_SLOW = 2'b00;
  localparam pre_code_t PRE_MID  = 2'b01;

  // Main-path divide ratio for a prescale code; codes 1x select the full rate.
  function automatic int unsigned pre_ratio(input pre_code_t code,
                                            input int unsigned slow_div,
                                            input int unsigned mid_div);
    case (code)
      PRE_SLOW: return slow_div;
      PRE_MID:  return mid_div;
      default:  return 1;
    endcase
  endfunction
endpackage

// File: rtl/cgen_div.sv
// Tick divider: counts ticks up to lim and flags the wrapping tick.
module cgen_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (tick)     cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cgen_standby.sv
// Halt / stop / settle-wait flags.
module cgen_standby (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic stop_req,
  input  logic irq_release,
  input  logic wait_release,
  output logic halt_ff,
  output logic stop_ff,
  output logic wait_ff,
  output logic running,
  output logic stop_set
);
  logic halt_set;

  assign running  = !(halt_ff || stop_ff || wait_ff);
  assign stop_set = running && stop_req;
  assign halt_set = running && halt_req && !stop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_ff <= 1'b0;
      stop_ff <= 1'b0;
      wait_ff <= 1'b0;
    end else begin
      if (halt_set)                  halt_ff <= 1'b1;
      else if (halt_ff && irq_release) halt_ff <= 1'b0;

      if (stop_set) stop_ff <= 1'b1;
      else if (stop_ff && irq_release) begin
        stop_ff <= 1'b0;
        wait_ff <= 1'b1;
      end else if (wait_ff && wait_release) wait_ff <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen #(
  parameter int SLOW_DIV = 16,
  parameter int MID_DIV  = 2,
  parameter int CYC_DIV  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       cfg_we,
  input  logic       cfg_sub,
  input  logic [1:0] cfg_pre,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       irq_release,
  input  logic       wait_release,
  output logic       cpu_ce,
  output logic       osc_en,
  output logic       halt_flag,
  output logic       stop_flag,
  output logic       wait_flag,
  output logic       cur_sub,
  output logic [1:0] cur_pre
);
  import cgen_pkg::*;

  localparam int PCW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int CCW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

  // Named internal events (also observed by the checker)
  logic      running, stop_set, cyc_bound, main_stage;
  logic      main_in, sub_in, cyc_tick;
  logic [PCW-1:0] pre_lim;
  logic      req_sub;
  pre_code_t req_pre;

  cgen_standby u_stby (
    .clk(clk), .rst_n(rst_n),
    .halt_req(halt_req), .stop_req(stop_req),
    .irq_release(irq_release), .wait_release(wait_release),
    .halt_ff(halt_flag), .stop_ff(stop_flag), .wait_ff(wait_flag),
    .running(running), .stop_set(stop_set)
  );

  assign osc_en  = !stop_flag;
  assign main_in = main_tick && !stop_flag;
  assign sub_in  = sub_tick && !stop_flag;
  assign pre_lim = PCW'(pre_ratio(cur_pre, SLOW_DIV, MID_DIV) - 1);

  cgen_div #(.W(PCW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(stop_set || cyc_bound),
    .tick(main_in), .lim(pre_lim), .wrap(main_stage)
  );

  assign cyc_tick = cur_sub ? sub_in : main_stage;

  cgen_div #(.W(CCW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(stop_set),
    .tick(cyc_tick), .lim(CCW'(CYC_DIV - 1)), .wrap(cyc_bound)
  );

  // Requested and active configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sub <= 1'b0;
      req_pre <= PRE_SLOW;
      cur_sub <= 1'b0;
      cur_pre <= PRE_SLOW;
    end else begin
      if (cfg_we) req_sub <= cfg_sub;
      if (stop_set)    req_pre <= PRE_SLOW;
      else if (cfg_we) req_pre <= cfg_pre;

      if (stop_set) cur_pre <= PRE_SLOW;
      else if (cyc_bound) begin
        cur_pre <= req_pre;
        cur_sub <= req_sub;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_ce <= 1'b0;
    else        cpu_ce <= cyc_bound && running;
  end
endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ce,
  input logic       osc_en,
  input logic       halt_flag,
  input logic       stop_flag,
  input logic       wait_flag,
  input logic       cur_sub,
  input logic [1:0] cur_pre,
  input logic       cyc_bound,
  input logic       stop_set
);
  p_ce_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);

  p_cfg_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cur_sub, cur_pre}) |-> $past(cyc_bound || stop_set));

  p_no_ce_standby_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_flag || stop_flag || wait_flag) |-> !cpu_ce);

  p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> (!osc_en && cur_pre == 2'b00));

  p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> (osc_en && wait_flag));

  p_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_flag, stop_flag, wait_flag}));
endmodule

bind cpu_clkgen cpu_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .osc_en(osc_en),
  .halt_flag(halt_flag), .stop_flag(stop_flag), .wait_flag(wait_flag),
  .cur_sub(cur_sub), .cur_pre(cur_pre),
  .cyc_bound(cyc_bound), .stop_set(stop_set)
);

// File: tb/cpu_clkgen_test.sv
`timescale 1ns/1ps
module cpu_clkgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_tick = 1'b1, sub_tick = 1'b0;
  logic cfg_we = 1'b0, cfg_sub = 1'b0;
  logic [1:0] cfg_pre = 2'b00;
  logic halt_req = 1'b0, stop_req = 1'b0, irq_release = 1'b0, wait_release = 1'b0;
  logic cpu_ce, osc_en, halt_flag, stop_flag, wait_flag, cur_sub;
  logic [1:0] cur_pre;
  int checks = 0, errors = 0;
  int sub_cnt = 0;

  always #5 clk = ~clk;

  cpu_clkgen uut (.*);

  // subsystem tick: one cycle in eight
  always @(negedge clk) begin
    sub_cnt  <= (sub_cnt == 7) ? 0 : sub_cnt + 1;
    sub_tick <= (sub_cnt == 7);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cfg_we = 0; halt_req = 0; stop_req = 0; irq_release = 0; wait_release = 0;
  endtask

  // cycles until the next sampled cpu_ce pulse (limit 2000)
  task automatic next_pulse(output int n);
    n = 0;
    do begin step(); n++; end while (!cpu_ce && n < 2000);
  endtask

  task automatic period(output int n);
    int d;
    next_pulse(d);
    next_pulse(n);
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    for (int i = 0; i < cycles; i++) begin step(); if (cpu_ce) p++; end
  endtask

  task automatic write_cfg(input logic s, input logic [1:0] p);
    cfg_we = 1; cfg_sub = s; cfg_pre = p;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    check(osc_en == 1, "R1 osc_en", osc_en, 1);
    check({halt_flag, stop_flag, wait_flag} == 0, "R1 flags", {halt_flag, stop_flag, wait_flag}, 0);
    check(cur_sub == 0 && cur_pre == 0, "R1 cfg", {cur_sub, cur_pre}, 0);
    check(cpu_ce == 0, "R1 cpu_ce", cpu_ce, 0);
    period(n);
    check(n == 64, "R2 period /16", n, 64);
  endtask

  task automatic t_prescale();
    int n, d;
    write_cfg(0, 2'b01); next_pulse(d); period(n);
    check(n == 8, "R2 period /2", n, 8);
    write_cfg(0, 2'b10); next_pulse(d); period(n);
    check(n == 4, "R2 period /1", n, 4);
    write_cfg(0, 2'b11); next_pulse(d); period(n);
    check(n == 4, "R2 period code 11", n, 4);
  endtask

  task automatic t_boundary();
    int n, d;
    write_cfg(0, 2'b00); next_pulse(d); next_pulse(d);
    write_cfg(0, 2'b01);
    step();
    check(cur_pre == 2'b00, "R4 cur_pre held before boundary", cur_pre, 0);
    next_pulse(n);
    check(n == 63, "R4 old interval length kept", n + 1, 64);
    check(cur_pre == 2'b01, "R4 cur_pre at boundary", cur_pre, 1);
    next_pulse(n);
    check(n == 8, "R4 new interval", n, 8);
  endtask

  task automatic t_sub();
    int n, d;
    write_cfg(1, 2'b10); next_pulse(d);
    check(cur_sub == 1, "R3 cur_sub", cur_sub, 1);
    period(n);
    check(n == 32, "R3 sub period", n, 32);
    main_tick = 0;
    period(n);
    check(n == 32, "R3 main_tick ignored", n, 32);
    main_tick = 1;
    write_cfg(0, 2'b10); next_pulse(d); period(n);
    check(n == 4 && cur_sub == 0, "R3 back to main", n, 4);
  endtask

  task automatic t_halt();
    int p, n;
    halt_req = 1; step();
    check(halt_flag == 1 && osc_en == 1, "R5 halt entry", {halt_flag, osc_en}, 3);
    count_pulses(100, p);
    check(p == 0, "R5 no cpu_ce in halt", p, 0);
    irq_release = 1;
    next_pulse(n);
    check(halt_flag == 0 && n <= 5, "R6 halt release resumes", n, 5);
  endtask

  task automatic t_stop();
    int p, n;
    halt_req = 0; stop_req = 1; step();
    check(stop_flag == 1 && osc_en == 0, "R7 stop entry", {stop_flag, osc_en}, 2);
    check(cur_pre == 2'b00, "R7 prescale cleared", cur_pre, 0);
    wait_release = 1; step();
    check(stop_flag == 1 && wait_flag == 0, "R8 wait_release ignored in stop", stop_flag, 1);
    count_pulses(100, p);
    check(p == 0, "R7 no cpu_ce in stop", p, 0);
    irq_release = 1; step();
    check(stop_flag == 0 && wait_flag == 1 && osc_en == 1, "R8 stop release",
          {stop_flag, wait_flag, osc_en}, 3);
    count_pulses(200, p);
    check(p == 0, "R8 gated until wait_release", p, 0);
    wait_release = 1;
    next_pulse(n);
    check(wait_flag == 0 && n <= 65, "R8 resume after wait_release", n, 65);
    next_pulse(n);
    check(n == 64, "R8 resumes at slow prescale", n, 64);
  endtask

  task automatic t_prio();
    halt_req = 1; stop_req = 1; step();
    check(stop_flag == 1 && halt_flag == 0, "R9 stop wins", {halt_flag, stop_flag}, 1);
    halt_req = 1; step();
    check(halt_flag == 0, "R9 halt ignored in stop", halt_flag, 0);
  endtask

  task automatic t_reset_stop();
    int n, d;
    do_reset();
    check(stop_flag == 0 && osc_en == 1, "R10 reset leaves stop", {stop_flag, osc_en}, 1);
    write_cfg(1, 2'b10); next_pulse(d); next_pulse(d);
    do_reset();
    check(cur_sub == 0 && cur_pre == 0, "R10 reset clears cfg", {cur_sub, cur_pre}, 0);
    period(n);
    check(n == 64, "R10 period after reset", n, 64);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_boundary();
    t_sub();
    write_cfg(0, 2'b10); begin int d; next_pulse(d); end
    t_halt();
    t_stop();
    t_prio();
    t_reset_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule